// File: doc/BRIEF.md
# Restoring Sequential Unsigned Divider

This block divides one unsigned N-bit integer by another over several clock cycles and returns an N-bit quotient and an N-bit remainder. A single wide working register carries both results. It is loaded with zero above and the dividend below, and it is shifted left once before the loop starts. In every iteration the divisor is taken from the upper part. A negative result is undone by adding the divisor back, and the register then shifts left while the new quotient bit enters at the bottom. One adder/subtractor does both the trial subtraction and the restore. Because of that, each iteration takes two cycles.

After N iterations only the upper part is shifted right by one place, which gives the remainder. The lower part holds the quotient. The upper part carries two guard bits above the N operand bits. The sign of the trial difference is therefore exact, and no bit is lost, even when both operands use their full unsigned range.

A caller pulses `start_i` with the operands while the unit is idle. It then waits for the single-cycle `done_o` pulse, and reads the results, which stay put until the next accepted start. A zero divisor is not flagged. The run still ends on schedule, with a quotient of all ones and a remainder equal to the dividend.

Top module: `seq_div`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A start accepted at clock edge E0 raises `busy_o` after E0. `done_o` is high for exactly one cycle after edge E0+2N+2. `busy_o` is low in that cycle.
- R3: For a non-zero divisor, `quotient_o` equals floor(dividend/divisor) and `remainder_o` equals dividend mod divisor. This holds across the full unsigned range, including operands with the top bit set. The remainder is always below the divisor.
- R4: For a zero divisor, the run ends with the same latency as any other run. `quotient_o` is all ones and `remainder_o` equals the dividend.
- R5: When `start_i` is asserted while `busy_o` is high, it is ignored. The running division completes with its original operands and its original timing.
- R6: While idle and without a new start, `quotient_o` and `remainder_o` hold their last values.
- R7: The operands are captured at the accepted start. Changes on `dividend_i` and `divisor_i` during a run do not affect the result.
- R8: With N=4, dividing 7 by 2 gives quotient 3 and remainder 1, which is the wide register value 0001_0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; accepted only while idle |
| dividend_i | input | N | Unsigned dividend, sampled at accepted start |
| divisor_i | input | N | Unsigned divisor, sampled at accepted start |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse when results are ready |
| quotient_o | output | N | Quotient of the last division |
| remainder_o | output | N | Remainder of the last division |

## Verification
The bench builds two instances. The default N=32 instance is driven with random operands and with directed extremes: the maximum value, a divisor with its top bit set, a dividend below the divisor, and a zero divisor. These runs also exercise starts issued mid-run and operands that change mid-run. A second instance with N=4 is driven through all 256 operand pairs, including the 7÷2 case. That instance brings every restore and no-restore path, and every zero-divisor case, into exhaustive reach.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SUB,
    ST_FIX,
    ST_FIN
  } div_state_e;
endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
  parameter int unsigned W = 34
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + W'(sub_i);
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic pre_o,
  output logic sub_o,
  output logic fix_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  div_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PRE;
      ST_PRE:  state_d = ST_SUB;
      ST_SUB:  state_d = ST_FIX;
      ST_FIX:  state_d = (cnt_q == LAST) ? ST_FIN : ST_SUB;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FIN);
      if (state_q == ST_PRE)      cnt_q <= '0;
      else if (state_q == ST_FIX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign pre_o  = (state_q == ST_PRE);
  assign sub_o  = (state_q == ST_SUB);
  assign fix_o  = (state_q == ST_FIX);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_sub_then_fix_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o |=> fix_o);
  p_fin_then_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> (done_o && !busy_o));
  p_busy_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         pre_i,
  input  logic         sub_i,
  input  logic         fix_i,
  input  logic         fin_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o,
  output logic [N-1:0] divisor_o
);
  // Upper part gets two guard bits: one for the shifted-up partial remainder, one for sign.
  localparam int unsigned W = N + 2;

  logic [W-1:0] hi_q;
  logic [N-1:0] lo_q;
  logic [N-1:0] dvs_q;
  logic [W-1:0] sum;
  logic [W-1:0] base;
  logic         neg;

  div_addsub #(.W(W)) u_addsub (
    .a_i   (hi_q),
    .b_i   ({2'b00, dvs_q}),
    .sub_i (sub_i),
    .sum_o (sum)
  );

  assign neg  = hi_q[W-1];
  assign base = neg ? sum : hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      hi_q  <= '0;
      lo_q  <= dividend_i;
      dvs_q <= divisor_i;
    end else if (pre_i) begin
      hi_q <= {hi_q[W-2:0], lo_q[N-1]};
      lo_q <= {lo_q[N-2:0], 1'b0};
    end else if (sub_i) begin
      hi_q <= sum;
    end else if (fix_i) begin
      hi_q <= {base[W-2:0], lo_q[N-1]};
      lo_q <= {lo_q[N-2:0], ~neg};
    end else if (fin_i) begin
      hi_q <= {1'b0, hi_q[W-1:1]};
    end
  end

  assign quotient_o  = lo_q;
  assign remainder_o = hi_q[N-1:0];
  assign divisor_o   = dvs_q;

  p_restore_nonneg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |=> !hi_q[W-1]);
  p_fin_clears_guard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (hi_q[W-1:N] == 2'b00));
  p_divisor_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i || fix_i) |=> $stable(dvs_q));
endmodule

// File: rtl/seq_div.sv
module seq_div #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o
);
  logic load, pre, sub, fix, fin;
  logic [N-1:0] dvs;

  div_ctrl #(.N(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .pre_o   (pre),
    .sub_o   (sub),
    .fix_o   (fix),
    .fin_o   (fin),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  div_datapath #(.N(N)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .pre_i       (pre),
    .sub_i       (sub),
    .fix_i       (fix),
    .fin_i       (fin),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .divisor_o   (dvs)
  );

  p_rem_below_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dvs != '0) |-> (remainder_o < dvs));
  p_zero_div_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dvs == '0) |-> (quotient_o == '1));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/seq_div_tb.sv
module seq_div_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        st32 = 1'b0, st4 = 1'b0;
  logic [31:0] dvd32 = '0, dvs32 = '0;
  logic [3:0]  dvd4 = '0, dvs4 = '0;
  logic        busy32, done32, busy4, done4;
  logic [31:0] q32, r32;
  logic [3:0]  q4, r4;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  seq_div #(.N(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st32), .dividend_i(dvd32), .divisor_i(dvs32),
    .busy_o(busy32), .done_o(done32), .quotient_o(q32), .remainder_o(r32));

  seq_div #(.N(4)) u_dut_n4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st4), .dividend_i(dvd4), .divisor_i(dvs4),
    .busy_o(busy4), .done_o(done4), .quotient_o(q4), .remainder_o(r4));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_q(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] ones = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    return (b == 0) ? ones : a / b;
  endfunction

  function automatic logic [31:0] exp_r(input logic [31:0] a, input logic [31:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // mode 0 plain, 1 start while busy (R5), 2 operands change mid-run (R7)
  task automatic run32(input logic [31:0] a, input logic [31:0] b, input int mode, input string tag);
    int lat;
    logic [31:0] eq, er;
    eq = exp_q(a, b, 32);
    er = exp_r(a, b);
    @(negedge clk); st32 = 1'b1; dvd32 = a; dvs32 = b;
    @(posedge clk);
    @(negedge clk); st32 = 1'b0;
    lat = 0;
    chk(busy32 == 1'b1, "R2 busy after start", 64'(busy32), 64'd1);
    if (mode == 1) begin
      st32 = 1'b1; dvd32 = ~a; dvs32 = b ^ 32'h5;
      @(posedge clk); lat++;
      @(negedge clk); st32 = 1'b0;
    end else if (mode == 2) begin
      dvd32 = $urandom; dvs32 = $urandom;
    end
    while (!done32 && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk(lat == 66, {tag, " latency"}, 64'(lat), 64'd66);
    chk(!busy32, "R2 busy low at done", 64'(busy32), 64'd0);
    chk(q32 == eq, {tag, " quotient"}, 64'(q32), 64'(eq));
    chk(r32 == er, {tag, " remainder"}, 64'(r32), 64'(er));
    @(posedge clk); @(negedge clk);
    chk(!done32, "R2 done single cycle", 64'(done32), 64'd0);
    dvd32 = $urandom; dvs32 = $urandom;
    repeat (2) @(negedge clk);
    chk(q32 == eq && r32 == er, "R6 hold quotient/remainder", {q32, r32}, {eq, er});
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input string tag);
    int lat;
    logic [31:0] eq, er;
    eq = exp_q(32'(a), 32'(b), 4);
    er = exp_r(32'(a), 32'(b));
    @(negedge clk); st4 = 1'b1; dvd4 = a; dvs4 = b;
    @(posedge clk);
    @(negedge clk); st4 = 1'b0;
    lat = 0;
    while (!done4 && lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk(lat == 10, {tag, " latency n4"}, 64'(lat), 64'd10);
    chk({r4, q4} == {er[3:0], eq[3:0]}, {tag, " n4 result"}, 64'({r4, q4}), 64'({er[3:0], eq[3:0]}));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy32 && !done32 && q32 == 0 && r32 == 0, "R1 reset n32", {busy32, done32, q32, r32}, 64'd0);
    chk(!busy4 && !done4 && q4 == 0 && r4 == 0, "R1 reset n4", 64'({busy4, done4, q4, r4}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy32 && q32 == 0 && r32 == 0, "R1 after release", {busy32, q32, r32[30:0]}, 64'd0);

    run4(4'd7, 4'd2, "R8");
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(4'(a), 4'(b), (b == 0) ? "R4" : "R3");

    run32(32'd100, 32'd7, 0, "R3");
    run32(32'hFFFF_FFFF, 32'd1, 0, "R3");
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
    run32(32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, "R3");
    run32(32'hF000_0001, 32'h8000_0001, 0, "R3");
    run32(32'd5, 32'd9, 0, "R3");
    run32(32'd0, 32'd3, 0, "R3");
    run32(32'hDEAD_BEEF, 32'd0, 0, "R4");
    run32(32'hFFFF_FFFF, 32'd0, 0, "R4");
    run32(32'd12345678, 32'd321, 1, "R5");
    run32(32'h8765_4321, 32'h0001_0003, 2, "R7");
    for (int i = 0; i < 240; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      if (i % 37 == 0) b = 0;
      run32(a, b, i % 3, (b == 0) ? "R4" : ((i % 3 == 1) ? "R5" : ((i % 3 == 2) ? "R7" : "R3")));
    end
    report();
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end
endmodule